// File: doc/BRIEF.md
# Interrupt Response and Halt Controller

This controller sits between an execution unit and its bus sequencer. It watches a level-sensitive maskable interrupt request. It accepts the request at an instruction boundary when the interrupt-enable flag is set. It then runs two back-to-back acknowledge bus cycles under a lock window and reads an 8-bit type byte during the second cycle. From that byte it presents a vector-table address equal to the type times four.

The controller also tracks the processor's halt state. On a halt request it emits a single address-latch pulse with no read strobe and then waits. Only an enabled interrupt or a reset ends the halt. A bus hold taken while halted does not end the halt; the halt pulse is issued again when the hold is released. Hold requests that arrive during an acknowledge sequence are held off until the second acknowledge cycle has ended. All outputs are registered.

Top module: `irq_halt_ctrl`

## Requirements
- R1: The request input passes through one synchronizing register. A boundary strobe leads to a response only if the request was already high at the clock edge before the boundary cycle. The response begins with ale high in the following cycle.
- R2: While ien_flag is low, a boundary strobe with the request high starts no response: ale and ien_clr stay low.
- R3: ien_clr is high for exactly one cycle, in the first cycle of a response, and is low in every other cycle of the sequence.
- R4: A response is two consecutive bus cycles. Each cycle has one T1 cycle with ale high, then one T2 cycle and one or more T3 cycles with ack_rd high, then one T4 cycle with both low. T3 repeats while bus_rdy is low at the clock edge.
- R5: lock_o is high from T2 of the first acknowledge cycle through T1 of the second, and is low from T2 of the second cycle onward.
- R6: A hold request raised during a response is not granted while the response runs. hold_ack rises in the cycle after the second T4 and falls in the cycle after hold_req drops.
- R7: bus_data is captured at the clock edge that ends the second cycle's T3 (bus_rdy high). vec_valid is then high for one cycle, the second T4, with vec_addr equal to the type byte shifted left by two bits (bits 9:2), all other bits zero. A byte present during the first cycle is not used.
- R8: A halt request from the running state gives one cycle with ale high and ack_rd low. halted is high from that cycle onward.
- R9: A hold granted while halted keeps halted high. When hold_req drops, hold_ack falls and one more ale pulse is issued while halted stays high.
- R10: While halted, boundary strobes and a request with ien_flag low do not end the halt. The request with ien_flag high ends it and starts a response. A reset also ends it.
- R11: A request held high is serviced again at a later boundary once ien_flag is set again.
- R12: In and after reset, ale, ack_rd, lock_o, hold_ack, halted, ien_clr, vec_valid and vec_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Level-sensitive maskable interrupt request |
| ien_flag | input | 1 | Interrupt-enable flag from the execution unit |
| insn_end | input | 1 | Instruction-boundary strobe |
| halt_req | input | 1 | Halt instruction executed |
| hold_req | input | 1 | Another master asks for the bus |
| bus_rdy | input | 1 | Bus ready; low stretches T3 |
| bus_data | input | TYPE_W | Type byte returned by the interrupt source |
| ale | output | 1 | Address-latch pulse (T1, or halt indication) |
| ack_rd | output | 1 | Acknowledge read strobe (T2 and T3) |
| lock_o | output | 1 | Bus lock during the acknowledge pair |
| hold_ack | output | 1 | Hold granted |
| halted | output | 1 | Processor in halt state |
| ien_clr | output | 1 | Pulse telling the execution unit to clear the enable flag |
| vec_addr | output | ADDR_W | Vector-table address, type times four |
| vec_valid | output | 1 | One-cycle strobe marking vec_addr as new |

## Verification
The bench builds the block with its defaults: an 8-bit type byte, a 20-bit vector address and a single synchronizing stage. A narrow type byte lets the bench sweep all 256 values through full responses and compute each expected address arithmetically. The sweep also varies the number of wait states from zero to two and puts a hold request inside every fifth response. With one synchronizer stage, the exact cycle in which a request becomes visible at a boundary can be tested directly. The halt path is driven through its hold, reissue, wake and reset exits.

// File: rtl/irq_hc_pkg.sv
package irq_hc_pkg;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_HALT_ALE,
    ST_HALT,
    ST_HOLD,
    ST_A1_T1,
    ST_A1_T2,
    ST_A1_T3,
    ST_A1_T4,
    ST_A2_T1,
    ST_A2_T2,
    ST_A2_T3,
    ST_A2_T4
  } hc_state_e;

  typedef struct packed {
    logic ale;
    logic ack_rd;
    logic lock;
    logic hold_ack;
    logic halted;
    logic ien_clr;
  } hc_out_s;

  // Output decode of a state; applied to the next state and registered.
  function automatic hc_out_s hc_decode(hc_state_e s, logic ret_halt);
    hc_out_s o;
    o          = '0;
    o.ale      = (s == ST_HALT_ALE) || (s == ST_A1_T1) || (s == ST_A2_T1);
    o.ack_rd   = (s == ST_A1_T2) || (s == ST_A1_T3) ||
                 (s == ST_A2_T2) || (s == ST_A2_T3);
    o.lock     = (s == ST_A1_T2) || (s == ST_A1_T3) ||
                 (s == ST_A1_T4) || (s == ST_A2_T1);
    o.hold_ack = (s == ST_HOLD);
    o.halted   = (s == ST_HALT_ALE) || (s == ST_HALT) ||
                 ((s == ST_HOLD) && ret_halt);
    o.ien_clr  = (s == ST_A1_T1);
    return o;
  endfunction

endpackage

// File: rtl/irq_hc_sampler.sv
module irq_hc_sampler #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  output logic irq_q
);

  generate
    if (SYNC_STAGES <= 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_req;
      end
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_STAGES-2:0], irq_req};
      end
      assign irq_q = sh_q[SYNC_STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/irq_hc_fsm.sv
module irq_hc_fsm
  import irq_hc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irq_q,
  input  logic ien_flag,
  input  logic insn_end,
  input  logic halt_req,
  input  logic hold_req,
  input  logic bus_rdy,
  output logic ale,
  output logic ack_rd,
  output logic lock_o,
  output logic hold_ack,
  output logic halted,
  output logic ien_clr,
  output logic cap_en
);

  hc_state_e st_q, st_d;
  logic      ret_q, ret_d;
  hc_out_s   out_q;
  logic      accept, wake;

  assign accept = insn_end && irq_q && ien_flag;
  assign wake   = irq_q && ien_flag;

  always_comb begin
    st_d  = st_q;
    ret_d = ret_q;
    unique case (st_q)
      ST_RUN: begin
        if (accept)        st_d = ST_A1_T1;
        else if (halt_req) st_d = ST_HALT_ALE;
        else if (hold_req) begin st_d = ST_HOLD; ret_d = 1'b0; end
      end
      ST_HALT_ALE, ST_HALT: begin
        if (wake)          st_d = ST_A1_T1;
        else if (hold_req) begin st_d = ST_HOLD; ret_d = 1'b1; end
        else               st_d = ST_HALT;
      end
      ST_HOLD:  if (!hold_req) st_d = ret_q ? ST_HALT_ALE : ST_RUN;
      ST_A1_T1: st_d = ST_A1_T2;
      ST_A1_T2: st_d = ST_A1_T3;
      ST_A1_T3: if (bus_rdy) st_d = ST_A1_T4;
      ST_A1_T4: st_d = ST_A2_T1;
      ST_A2_T1: st_d = ST_A2_T2;
      ST_A2_T2: st_d = ST_A2_T3;
      ST_A2_T3: if (bus_rdy) st_d = ST_A2_T4;
      ST_A2_T4: begin
        ret_d = 1'b0;
        st_d  = hold_req ? ST_HOLD : ST_RUN;
      end
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RUN;
      ret_q <= 1'b0;
      out_q <= '0;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
      out_q <= hc_decode(st_d, ret_d);
    end
  end

  assign ale      = out_q.ale;
  assign ack_rd   = out_q.ack_rd;
  assign lock_o   = out_q.lock;
  assign hold_ack = out_q.hold_ack;
  assign halted   = out_q.halted;
  assign ien_clr  = out_q.ien_clr;
  assign cap_en   = (st_q == ST_A2_T3) && bus_rdy;

  // R1: a response only starts from a boundary with a sampled request
  a_r1_start_needs_boundary: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && st_d == ST_A1_T1) |-> (insn_end && irq_q));

  // R3: enable clear lasts one cycle
  a_r3_clr_single: assert property (@(posedge clk) disable iff (rst)
    ien_clr |=> !ien_clr);

endmodule

// File: rtl/irq_hc_vec.sv
module irq_hc_vec #(
  parameter int TYPE_W     = 8,
  parameter int ADDR_W     = 20,
  parameter int SCALE_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [TYPE_W-1:0] bus_data,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              vec_valid
);

  localparam int PAD_W = ADDR_W - TYPE_W - SCALE_LOG2;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_addr  <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= cap_en;
      if (cap_en) vec_addr <= {{PAD_W{1'b0}}, bus_data, {SCALE_LOG2{1'b0}}};
    end
  end

  // R7: the vector strobe is a single-cycle pulse
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl #(
  parameter int TYPE_W      = 8,
  parameter int ADDR_W      = 20,
  parameter int SCALE_LOG2  = 2,
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_req,
  input  logic              ien_flag,
  input  logic              insn_end,
  input  logic              halt_req,
  input  logic              hold_req,
  input  logic              bus_rdy,
  input  logic [TYPE_W-1:0] bus_data,
  output logic              ale,
  output logic              ack_rd,
  output logic              lock_o,
  output logic              hold_ack,
  output logic              halted,
  output logic              ien_clr,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              vec_valid
);

  logic irq_q;
  logic cap_en;

  irq_hc_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk     (clk),
    .rst     (rst),
    .irq_req (irq_req),
    .irq_q   (irq_q)
  );

  irq_hc_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .irq_q    (irq_q),
    .ien_flag (ien_flag),
    .insn_end (insn_end),
    .halt_req (halt_req),
    .hold_req (hold_req),
    .bus_rdy  (bus_rdy),
    .ale      (ale),
    .ack_rd   (ack_rd),
    .lock_o   (lock_o),
    .hold_ack (hold_ack),
    .halted   (halted),
    .ien_clr  (ien_clr),
    .cap_en   (cap_en)
  );

  irq_hc_vec #(
    .TYPE_W     (TYPE_W),
    .ADDR_W     (ADDR_W),
    .SCALE_LOG2 (SCALE_LOG2)
  ) u_vec (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .bus_data  (bus_data),
    .vec_addr  (vec_addr),
    .vec_valid (vec_valid)
  );

  // R2: the enable clear follows only a cycle where the flag was set
  a_r2_clr_needs_enable: assert property (@(posedge clk) disable iff (rst)
    ien_clr |-> $past(ien_flag));

  // R3: enable clear coincides with the first address-latch pulse
  a_r3_clr_with_ale: assert property (@(posedge clk) disable iff (rst)
    ien_clr |-> ale);

  // R4: the read strobe rises right after a T1 pulse
  a_r4_ack_after_t1: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_rd) |-> $past(ale));

  // R5: no hold is granted inside the lock window
  a_r5_lock_no_hold: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> !hold_ack);

  // R6: no hold grant while an acknowledge strobe is active
  a_r6_ack_no_hold: assert property (@(posedge clk) disable iff (rst)
    ack_rd |-> !hold_ack);

  // R7: the vector appears after the second read strobe, outside the lock
  a_r7_vec_after_ack: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ($past(ack_rd) && !lock_o));

  // R10: leaving halt without reset only happens into a response
  a_r10_halt_exit: assert property (@(posedge clk) disable iff (rst)
    ($fell(halted) && !$past(rst)) |-> (ale && ien_clr));

endmodule

// File: tb/tb_irq_halt_ctrl.sv
`timescale 1ns/1ps
module tb_irq_halt_ctrl;

  localparam int TYPE_W = 8;
  localparam int ADDR_W = 20;

  logic clk = 1'b0;
  logic rst, irq_req, ien_flag, insn_end, halt_req, hold_req, bus_rdy;
  logic [TYPE_W-1:0] bus_data;
  logic ale, ack_rd, lock_o, hold_ack, halted, ien_clr, vec_valid;
  logic [ADDR_W-1:0] vec_addr;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_halt_ctrl #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .ien_flag(ien_flag),
    .insn_end(insn_end), .halt_req(halt_req), .hold_req(hold_req),
    .bus_rdy(bus_rdy), .bus_data(bus_data), .ale(ale), .ack_rd(ack_rd),
    .lock_o(lock_o), .hold_ack(hold_ack), .halted(halted),
    .ien_clr(ien_clr), .vec_addr(vec_addr), .vec_valid(vec_valid)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {ale, ack_rd, lock_o, hold_ack, halted}
  task automatic chk_bus(input string tag, input logic [4:0] exp);
    chk(tag, {27'b0, ale, ack_rd, lock_o, hold_ack, halted}, {27'b0, exp});
  endtask

  // Entered at the negedge where the first T1 is visible.
  task automatic ack_body(input logic [7:0] t, input int w, input bit hreq);
    for (int c = 1; c <= 2; c++) begin
      chk_bus("R4 R5 T1", {1'b1, 1'b0, (c == 2), 1'b0, 1'b0});
      chk("R3 clear pulse", {31'b0, ien_clr}, {31'b0, (c == 1)});
      if (c == 1) begin
        ien_flag = 1'b0;
        if (hreq) hold_req = 1'b1;
      end
      tick();
      chk_bus("R4 R5 T2", {1'b0, 1'b1, (c == 1), 1'b0, 1'b0});
      chk("R3 no clear in T2", {31'b0, ien_clr}, 32'd0);
      tick();
      for (int i = 0; i <= w; i++) begin
        chk_bus("R4 R6 T3", {1'b0, 1'b1, (c == 1), 1'b0, 1'b0});
        bus_rdy  = (i == w);
        bus_data = (c == 2) ? t : ~t;
        tick();
      end
      bus_rdy = 1'b0;
      chk_bus("R4 R5 T4", {1'b0, 1'b0, (c == 1), 1'b0, 1'b0});
      chk("R7 valid", {31'b0, vec_valid}, {31'b0, (c == 2)});
      if (c == 2) chk("R7 vector", {12'b0, vec_addr}, {12'b0, 12'b0, t, 2'b00});
      tick();
    end
    chk("R7 valid drops", {31'b0, vec_valid}, 32'd0);
    if (hreq) begin
      chk_bus("R6 hold granted after second T4", 5'b00010);
      hold_req = 1'b0;
      tick();
      chk_bus("R6 hold released", 5'b00000);
    end else begin
      chk_bus("R4 back to run", 5'b00000);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irq_req = 1'b0; ien_flag = 1'b0; insn_end = 1'b0;
    halt_req = 1'b0; hold_req = 1'b0; bus_rdy = 1'b0; bus_data = '0;
    repeat (3) tick();
    chk_bus("R12 in reset", 5'b00000);
    chk("R12 vector in reset", {11'b0, vec_valid, vec_addr}, 32'd0);
    rst = 1'b0;
    tick();
    chk_bus("R12 after reset", 5'b00000);
    chk("R12 vector after reset", {10'b0, ien_clr, vec_valid, vec_addr}, 32'd0);

    // R2: enable flag low blocks the response
    irq_req = 1'b1;
    tick();
    ien_flag = 1'b0; insn_end = 1'b1;
    tick();
    insn_end = 1'b0;
    chk_bus("R2 masked request", 5'b00000);
    chk("R2 no clear", {31'b0, ien_clr}, 32'd0);
    tick();
    chk_bus("R2 still idle", 5'b00000);

    // R1: request raised in the boundary cycle itself is not yet seen
    irq_req = 1'b0;
    tick(); tick();
    irq_req = 1'b1; ien_flag = 1'b1; insn_end = 1'b1;
    tick();
    chk_bus("R1 unsynchronized request ignored", 5'b00000);
    tick();
    insn_end = 1'b0;
    ack_body(8'h5A, 0, 1'b0);

    // R11 and R7 sweep: request held high, serviced at every enabled boundary
    for (int t = 0; t < 256; t++) begin
      tick();
      ien_flag = 1'b1; insn_end = 1'b1;
      tick();
      insn_end = 1'b0;
      ack_body(t[7:0], t % 3, (t % 5) == 0);
    end

    // R8: halt entry
    tick();
    halt_req = 1'b1;
    tick();
    halt_req = 1'b0;
    chk_bus("R8 halt pulse", 5'b10001);
    tick();
    chk_bus("R8 halted quiet", 5'b00001);

    // R10: boundary strobes with the flag low do not end halt
    insn_end = 1'b1; halt_req = 1'b1;
    tick();
    insn_end = 1'b0; halt_req = 1'b0;
    chk_bus("R10 halt kept", 5'b00001);
    tick();
    chk_bus("R10 halt kept later", 5'b00001);

    // R9: hold during halt, then reissued pulse
    hold_req = 1'b1;
    tick();
    chk_bus("R9 hold in halt", 5'b00011);
    tick();
    chk_bus("R9 hold in halt held", 5'b00011);
    hold_req = 1'b0;
    tick();
    chk_bus("R9 halt pulse reissued", 5'b10001);
    tick();
    chk_bus("R9 halted after reissue", 5'b00001);

    // R10: enabled request wakes the halt into a response
    ien_flag = 1'b1;
    tick();
    ack_body(8'hC3, 1, 1'b0);

    // R10: reset ends halt
    tick();
    halt_req = 1'b1;
    tick();
    halt_req = 1'b0;
    tick();
    chk_bus("R10 halted before reset", 5'b00001);
    rst = 1'b1;
    tick();
    chk_bus("R10 reset clears halt", 5'b00000);
    rst = 1'b0;
    tick();
    chk_bus("R12 run after reset", 5'b00000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule